// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates maskable interrupts for a small 8-bit processor core. Six request slots of fixed priority each carry a sticky request flag and an enable bit, and one global enable gates them all. Two slots take their source from a configuration input. The lowest-priority slot gathers three sub-sources through a second bank of sticky sub-flags with their own enables.

Requests are edge-detected and latched at any time. On each instruction-phase strobe the controller looks at the pending flags. If the global enable is set and the core's return stack has room, it picks the highest-priority enabled request. It then raises an acknowledge with the call vector for that slot, clears the slot's flag and drops the global enable, so that nested service must be allowed explicitly. A return-with-enable pulse from the core sets the global enable again. Software reads flags and enables on dedicated outputs and writes them through a small select/data port.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Slot k (k = 1..6, flag and enable bit k-1) has priority k, with 1 the highest, and is acknowledged with vector 4*k (04H, 08H, 0CH, 10H, 14H, 18H).
- R2: A slot is serviced at a strobe only if the global enable, that slot's enable and the inverse of `stack_full` are all 1 in that cycle. Otherwise the strobe produces no acknowledge and changes no flag.
- R3: At the edge where a slot is acknowledged, that slot's flag and the global enable are both cleared.
- R4: Requests latched since the previous strobe are evaluated together at the next strobe, and the highest-priority enabled pending slot wins.
- R5: A request flag stays set, whatever its enable, until it is acknowledged or overwritten by software.
- R6: A `ret_ie` pulse sets the global enable. If an acknowledge happens in the same cycle, the global enable ends up 0.
- R7: `cfg_slot1_adc` = 0 routes `req_ext0` to slot 1 and ignores `req_adc`. A value of 1 does the reverse.
- R8: `cfg_ser_late` = 0 puts `req_ser` in slot 2 and `req_uart` in slot 5, and ignores `req_ext1`. A value of 1 puts `req_ext1` in slot 2 and `req_ser` in slot 5, and ignores `req_uart`.
- R9: Sub-flags 0/1/2 latch rising edges of `req_tmr2`/`req_rtc`/`req_tbase`. An acknowledge never clears them. The slot 6 flag is set on the rising edge of the OR of the sub-flags ANDed with the sub-enables.
- R10: Flags latch on rising edges of their request, not on levels. A hardware set in the same cycle as a software write or an acknowledge clear leaves the flag at 1.
- R11: `ack_o` and `vec_o` change only at strobe edges and hold for a whole strobe period. `vec_o` is 0 whenever `ack_o` is 0.
- R12: Synchronous reset clears all flags, enables, the global enable, `ack_o` and `vec_o`. No acknowledge occurs while reset is held.
- R13: Software writes with `wr_en`, using `wr_sel`. 0 writes the slot flags from `wr_data[5:0]`. 1 writes the slot enables from `wr_data[5:0]` and the global enable from `wr_data[6]`. 2 writes the sub-flags from `wr_data[2:0]`. 3 writes the sub-enables from `wr_data[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_stb | input | 1 | Instruction-phase strobe, one cycle wide |
| cfg_slot1_adc | input | 1 | Slot 1 source select |
| cfg_ser_late | input | 1 | Serial request placement select |
| req_ext0 | input | 1 | External request 0 |
| req_adc | input | 1 | Converter-done request |
| req_ext1 | input | 1 | External request 1 |
| req_ser | input | 1 | Serial shift-complete request |
| req_tmr0 | input | 1 | Timer 0 overflow |
| req_tmr1 | input | 1 | Timer 1 overflow |
| req_uart | input | 1 | UART request |
| req_tmr2 | input | 1 | Timer 2 overflow (sub-source 0) |
| req_rtc | input | 1 | Real-time clock tick (sub-source 1) |
| req_tbase | input | 1 | Time-base tick (sub-source 2) |
| stack_full | input | 1 | Core return stack has no free entry |
| ret_ie | input | 1 | Return-with-enable pulse |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 7 | Write data |
| ack_o | output | 1 | Acknowledge, held one strobe period |
| vec_o | output | 8 | Call vector address |
| flags_o | output | 6 | Slot request flags |
| en_o | output | 6 | Slot enables |
| gie_o | output | 1 | Global enable |
| mf_flags_o | output | 3 | Sub-flags |
| mf_en_o | output | 3 | Sub-enables |

## Verification
The bench builds the block with its default parameters: six slots, three sub-sources and a vector step of 4. At that size every combination of slot flags and slot enables can be swept, which gives 4096 strobes. For each strobe the bench computes the winning slot, its vector and the remaining flags arithmetically, so every priority ordering and every masking case is covered. Directed sequences then cover the source selections, stack-full blocking, edge-versus-level behaviour, same-cycle set/clear races, the sub-flag gathering and the reset behaviour.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam logic [1:0] SEL_FLAGS = 2'd0;
  localparam logic [1:0] SEL_EN    = 2'd1;
  localparam logic [1:0] SEL_SUBF  = 2'd2;
  localparam logic [1:0] SEL_SUBEN = 2'd3;
endpackage

// File: rtl/irq_flag_bank.sv
// Sticky edge-detected request flags; a hardware set beats any clear.
module irq_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  input  logic         wr_i,
  input  logic [N-1:0] wr_val_i,
  output logic [N-1:0] flag_o
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_bit
      logic prev_q;
      logic flag_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          prev_q <= req_i[g];
          if (req_i[g] && !prev_q) flag_q <= 1'b1;
          else if (wr_i)           flag_q <= wr_val_i[g];
          else if (clr_i[g])       flag_q <= 1'b0;
        end
      end
      assign flag_o[g] = flag_q;

      p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (req_i[g] && !prev_q) |=> flag_q);
      p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !wr_i && !clr_i[g]) |=> flag_q);
    end
  endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority pick: lowest index wins.
module irq_prio_pick #(
  parameter int N  = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int NSLOT    = 6,
  parameter int NSUB     = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4,
  localparam int DW      = NSLOT + 1,
  localparam int IW      = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_stb,
  input  logic             cfg_slot1_adc,
  input  logic             cfg_ser_late,
  input  logic             req_ext0,
  input  logic             req_adc,
  input  logic             req_ext1,
  input  logic             req_ser,
  input  logic             req_tmr0,
  input  logic             req_tmr1,
  input  logic             req_uart,
  input  logic             req_tmr2,
  input  logic             req_rtc,
  input  logic             req_tbase,
  input  logic             stack_full,
  input  logic             ret_ie,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic             ack_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NSLOT-1:0] flags_o,
  output logic [NSLOT-1:0] en_o,
  output logic             gie_o,
  output logic [NSUB-1:0]  mf_flags_o,
  output logic [NSUB-1:0]  mf_en_o
);
  logic [NSLOT-1:0] slot_req, slot_flag, slot_en_q, masked, grant, clr_slot;
  logic [NSUB-1:0]  sub_flag, sub_en_q;
  logic [IW-1:0]    pick_idx;
  logic             pick_any, serve, gie_q, ack_q, mf_any;
  logic [VEC_W-1:0] vec_q, vec_next;

  // Sub-source gathering for the lowest-priority slot
  irq_flag_bank #(.N(NSUB)) u_sub (
    .clk(clk), .rst(rst),
    .req_i({req_tbase, req_rtc, req_tmr2}),
    .clr_i('0),
    .wr_i(wr_en && wr_sel == SEL_SUBF),
    .wr_val_i(wr_data[NSUB-1:0]),
    .flag_o(sub_flag)
  );
  assign mf_any = |(sub_flag & sub_en_q);

  // Source routing per configuration
  always_comb begin
    slot_req           = '0;
    slot_req[0]        = cfg_slot1_adc ? req_adc  : req_ext0;
    slot_req[1]        = cfg_ser_late  ? req_ext1 : req_ser;
    slot_req[2]        = req_tmr0;
    slot_req[3]        = req_tmr1;
    slot_req[4]        = cfg_ser_late  ? req_ser  : req_uart;
    slot_req[NSLOT-1]  = mf_any;
  end

  assign clr_slot = grant & {NSLOT{serve}};

  irq_flag_bank #(.N(NSLOT)) u_slots (
    .clk(clk), .rst(rst),
    .req_i(slot_req),
    .clr_i(clr_slot),
    .wr_i(wr_en && wr_sel == SEL_FLAGS),
    .wr_val_i(wr_data[NSLOT-1:0]),
    .flag_o(slot_flag)
  );

  assign masked = slot_flag & slot_en_q & {NSLOT{gie_q && !stack_full}};

  irq_prio_pick #(.N(NSLOT)) u_pick (
    .req_i(masked), .grant_o(grant), .idx_o(pick_idx), .any_o(pick_any)
  );

  assign serve    = phase_stb && pick_any;
  assign vec_next = VEC_W'((32'(pick_idx) + 1) * VEC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else if (phase_stb) begin
      ack_q <= pick_any;
      vec_q <= pick_any ? vec_next : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q     <= 1'b0;
      slot_en_q <= '0;
      sub_en_q  <= '0;
    end else begin
      if (serve)                          gie_q <= 1'b0;
      else if (ret_ie)                    gie_q <= 1'b1;
      else if (wr_en && wr_sel == SEL_EN) gie_q <= wr_data[NSLOT];
      if (wr_en && wr_sel == SEL_EN)    slot_en_q <= wr_data[NSLOT-1:0];
      if (wr_en && wr_sel == SEL_SUBEN) sub_en_q  <= wr_data[NSUB-1:0];
    end
  end

  assign ack_o      = ack_q;
  assign vec_o      = vec_q;
  assign flags_o    = slot_flag;
  assign en_o       = slot_en_q;
  assign gie_o      = gie_q;
  assign mf_flags_o = sub_flag;
  assign mf_en_o    = sub_en_q;

  p_vec_slot_r1: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> ((32'(vec_q) % VEC_STEP) == 0 && 32'(vec_q) >= VEC_STEP
               && 32'(vec_q) <= NSLOT * VEC_STEP));
  p_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_stb && (stack_full || !gie_q)) |=> !ack_q);
  p_gie_drop_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> !gie_q);
  p_grant_subset_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~masked) == '0));
  p_ret_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (ret_ie && !serve) |=> gie_q);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !phase_stb |=> ($stable(ack_q) && $stable(vec_q)));
  p_idle_vec_r11: assert property (@(posedge clk) disable iff (rst)
    !ack_q |-> (vec_q == '0));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb_top;
  logic clk = 0, rst = 1, phase_stb = 0, cfg_slot1_adc = 0, cfg_ser_late = 0;
  logic req_ext0 = 0, req_adc = 0, req_ext1 = 0, req_ser = 0, req_tmr0 = 0;
  logic req_tmr1 = 0, req_uart = 0, req_tmr2 = 0, req_rtc = 0, req_tbase = 0;
  logic stack_full = 0, ret_ie = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [6:0] wr_data = 0;
  logic ack_o, gie_o;
  logic [7:0] vec_o;
  logic [5:0] flags_o, en_o;
  logic [2:0] mf_flags_o, mf_en_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk(clk), .rst(rst), .phase_stb(phase_stb), .cfg_slot1_adc(cfg_slot1_adc),
    .cfg_ser_late(cfg_ser_late), .req_ext0(req_ext0), .req_adc(req_adc),
    .req_ext1(req_ext1), .req_ser(req_ser), .req_tmr0(req_tmr0), .req_tmr1(req_tmr1),
    .req_uart(req_uart), .req_tmr2(req_tmr2), .req_rtc(req_rtc), .req_tbase(req_tbase),
    .stack_full(stack_full), .ret_ie(ret_ie), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack_o(ack_o), .vec_o(vec_o), .flags_o(flags_o), .en_o(en_o),
    .gie_o(gie_o), .mf_flags_o(mf_flags_o), .mf_en_o(mf_en_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [6:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 0; wr_data = 0;
  endtask

  task automatic strobe();
    phase_stb = 1;
    tick();
    phase_stb = 0;
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: req_ext0 = v;  1: req_adc = v;  2: req_ext1 = v;  3: req_ser = v;
      4: req_tmr0 = v;  5: req_tmr1 = v; 6: req_uart = v;  7: req_tmr2 = v;
      8: req_rtc = v;   default: req_tbase = v;
    endcase
  endtask

  task automatic pulse(input int s);
    set_src(s, 1);
    tick();
    set_src(s, 0);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state, no acknowledge while reset held
    tick(); tick();
    phase_stb = 1; tick(); phase_stb = 0;
    chk("R12 ack in reset", ack_o, 0);
    rst = 0; tick();
    chk("R12 flags after reset", flags_o, 0);
    chk("R12 en after reset", en_o, 0);
    chk("R12 gie after reset", gie_o, 0);
    chk("R12 vec after reset", vec_o, 0);

    // R1 R2 R3 R4 R13: exhaustive flag x enable sweep
    for (int f = 0; f < 64; f++) begin
      for (int e = 0; e < 64; e++) begin
        int m, idx;
        m = f & e;
        idx = -1;
        for (int k = 5; k >= 0; k--) if (m[k]) idx = k;
        wr(2'd0, 7'(f));
        wr(2'd1, {1'b1, 6'(e)});
        strobe();
        if (idx >= 0) begin
          chk("R1 R4 sweep ack", ack_o, 1);
          chk("R1 R4 sweep vec", vec_o, 4 * (idx + 1));
          chk("R3 sweep flags", flags_o, f & ~(1 << idx));
          chk("R3 sweep gie", gie_o, 0);
        end else begin
          chk("R2 sweep ack", ack_o, 0);
          chk("R2 sweep flags", flags_o, f);
          chk("R13 sweep gie", gie_o, 1);
        end
      end
    end
    wr(2'd0, 0); wr(2'd1, 0);
    strobe();

    // R11: hold over a strobe period
    wr(2'd0, 7'h04); wr(2'd1, 7'h44);
    strobe();
    chk("R11 ack", ack_o, 1); chk("R11 vec", vec_o, 8'h0C);
    repeat (5) tick();
    chk("R11 ack held", ack_o, 1); chk("R11 vec held", vec_o, 8'h0C);
    strobe();
    chk("R11 ack drop", ack_o, 0); chk("R11 vec zero", vec_o, 0);

    // R2: stack full blocks, global enable off blocks
    wr(2'd0, 7'h01); wr(2'd1, 7'h7F);
    stack_full = 1; strobe();
    chk("R2 stack full ack", ack_o, 0);
    chk("R2 stack full flag", flags_o, 1);
    chk("R2 stack full gie", gie_o, 1);
    stack_full = 0; strobe();
    chk("R2 stack free vec", vec_o, 8'h04);
    wr(2'd0, 7'h02); wr(2'd1, 7'h3F);
    strobe();
    chk("R2 gie off ack", ack_o, 0);

    // R5: flag persists while disabled
    wr(2'd0, 0); wr(2'd1, 7'h40);
    pulse(5);
    chk("R5 flag set", flags_o, 6'h08);
    strobe(); repeat (6) tick(); strobe();
    chk("R5 flag kept", flags_o, 6'h08);
    chk("R5 no ack", ack_o, 0);
    wr(2'd1, 7'h48);
    strobe();
    chk("R5 served vec", vec_o, 8'h10);

    // R6: return-with-enable
    chk("R6 gie low", gie_o, 0);
    ret_ie = 1; tick(); ret_ie = 0;
    chk("R6 gie set", gie_o, 1);
    wr(2'd0, 7'h01); wr(2'd1, 7'h41);
    phase_stb = 1; ret_ie = 1; tick(); phase_stb = 0; ret_ie = 0;
    chk("R6 same-cycle ack", ack_o, 1);
    chk("R6 same-cycle gie", gie_o, 0);

    // R10: edge not level; set wins
    wr(2'd0, 0); wr(2'd1, 0);
    req_tmr0 = 1; tick();
    chk("R10 edge set", flags_o, 6'h04);
    wr(2'd0, 0);
    repeat (3) tick();
    chk("R10 level ignored", flags_o, 0);
    req_tmr0 = 0; tick();
    wr_en = 1; wr_sel = 2'd0; wr_data = 0; req_tmr1 = 1;
    tick();
    wr_en = 0; req_tmr1 = 0;
    chk("R10 set beats write", flags_o, 6'h08);
    wr(2'd0, 7'h01); wr(2'd1, 7'h41);
    phase_stb = 1; req_ext0 = 1; tick(); phase_stb = 0; req_ext0 = 0;
    chk("R10 ack vec", vec_o, 8'h04);
    chk("R10 set beats ack", flags_o, 6'h01);

    // R7: slot 1 source
    wr(2'd0, 0); wr(2'd1, 0); tick();
    cfg_slot1_adc = 0;
    pulse(1); chk("R7 adc ignored", flags_o, 0);
    pulse(0); chk("R7 ext0 routed", flags_o, 6'h01);
    wr(2'd0, 0); cfg_slot1_adc = 1; tick();
    pulse(0); chk("R7 ext0 ignored", flags_o, 0);
    pulse(1); chk("R7 adc routed", flags_o, 6'h01);
    wr(2'd0, 0); cfg_slot1_adc = 0; tick();

    // R8: serial placement
    cfg_ser_late = 0;
    pulse(3); chk("R8 ser early", flags_o, 6'h02);
    wr(2'd0, 0);
    pulse(2); chk("R8 ext1 ignored", flags_o, 0);
    pulse(6); chk("R8 uart slot5", flags_o, 6'h10);
    wr(2'd0, 0); cfg_ser_late = 1; tick();
    pulse(3); chk("R8 ser late", flags_o, 6'h10);
    wr(2'd0, 0);
    pulse(2); chk("R8 ext1 slot2", flags_o, 6'h02);
    wr(2'd0, 0);
    pulse(6); chk("R8 uart ignored", flags_o, 0);
    cfg_ser_late = 0; tick();

    // R9: multi-function gathering
    wr(2'd3, 7'h02);
    chk("R9 sub enables", mf_en_o, 3'b010);
    pulse(7); tick();
    chk("R9 tmr2 subflag", mf_flags_o, 3'b001);
    chk("R9 masked sub no slot", flags_o, 0);
    pulse(8);
    chk("R9 rtc subflag", mf_flags_o, 3'b011);
    chk("R9 slot6 flag", flags_o, 6'h20);
    wr(2'd1, 7'h60);
    strobe();
    chk("R9 vec 18", vec_o, 8'h18);
    chk("R9 slot flag cleared", flags_o, 0);
    chk("R9 subflags kept", mf_flags_o, 3'b011);
    wr(2'd2, 0);
    chk("R9 sw clear", mf_flags_o, 0);
    pulse(9);
    chk("R9 tbase subflag", mf_flags_o, 3'b100);

    // R12: reset mid-run
    wr(2'd0, 7'h3F); wr(2'd1, 7'h7F);
    rst = 1; phase_stb = 1; tick(); phase_stb = 0;
    chk("R12 no ack in reset", ack_o, 0);
    rst = 0; tick();
    chk("R12 flags cleared", flags_o, 0);
    chk("R12 enables cleared", en_o, 0);
    chk("R12 subflags cleared", mf_flags_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule